// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

The block takes a transmit frame that software or an upstream DMA has placed in a small byte-addressed buffer inside the block. The frame begins with an 8-byte control block. The first byte of that control block carries offload flags, and two further bytes locate the network header and the transport header. When the block is started, it makes one pass over the frame and accumulates the requested checksums: the IPv4 header checksum, and a TCP or UDP checksum that includes the IPv4 pseudo-header. It then streams the frame out one byte per cycle, with the control block stripped and the computed checksums substituted at their fields.

A frame with UDP selected but no UDP checksum requested leaves with its checksum field zeroed. A frame that is not marked IPv4 passes through untouched, whatever its other flag bits say.

The buffer is loaded through a simple byte write port while the block is idle. Each accepted start produces exactly one contiguous output burst, and the next frame may be started once `busy` drops.

Top module: `tx_csum_offload`

## Requirements
- R1: Control-block layout. Byte 0 holds the flags: bit 7 marks an IPv4 frame, bit 6 marks a TCP/UDP transport header, bit 5 selects UDP (0 selects TCP), bit 4 requests the IPv4 header checksum, and bit 3 requests the transport checksum. Byte 3 is the offset of the IPv4 header counted from buffer byte 8 (L3 = 8 + byte3). Byte 2 is the offset of the transport header counted from L3 (L4 = L3 + byte2).
- R2: Output is buffer bytes 8 to frame_len-1 in order, one per cycle with `out_valid` high, and `out_last` marks the final byte. Bytes outside the checksum fields leave unchanged.
- R3: When bits 7 and 4 are both set, the IPv4 header checksum is written big-endian at L3+10/L3+11. The checksum is the inverted 16-bit ones-complement sum of big-endian words over IHL*4 bytes starting at L3, with IHL taken as the low nibble of byte L3 and the old field counted as zero.
- R4: Transport processing happens only when bits 7 and 6 are both set. For TCP with bit 3 set, the TCP checksum is written at L4+16/L4+17.
- R5: For UDP with bit 3 set, the UDP checksum is written at L4+6/L4+7. A computed value of 0x0000 is sent as 0xFFFF.
- R6: For UDP with bit 3 clear, bytes L4+6 and L4+7 are sent as zero.
- R7: The transport checksum covers the pseudo-header and then the bytes from L4 to the frame end. The pseudo-header is the source and destination addresses (L3+12..L3+19), the protocol byte at L3+9 as a word with a zero high byte, and the length frame_len - L4. An odd trailing byte is padded with a zero low byte, and the old checksum field is counted as zero.
- R8: With bit 7 clear, the frame is output unchanged whatever bits 6 to 3 hold.
- R9: After an accepted start, `busy` rises on the next edge. The first byte appears frame_len-8 cycles after that edge. The burst is unbroken, and `busy` falls on the edge after the byte with `out_last`.
- R10: `start` is ignored while `busy` is high. It is also ignored when frame_len is 8 or less, or above the buffer depth: in those cases there is no output and `busy` stays low.
- R11: During and after reset, `busy`, `out_valid` and `out_last` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Buffer byte write strobe |
| wr_addr | input | ADDR_W | Buffer byte address |
| wr_data | input | 8 | Buffer byte value |
| start | input | 1 | Begin processing the buffered frame |
| frame_len | input | ADDR_W+1 | Frame length in bytes including the control block |
| busy | output | 1 | Frame in progress |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the frame |

## Verification
The bench goes after odd transport lengths, where a design that pads on the wrong side or drops the last byte emits a wrong TCP checksum. It covers an IPv4 header longer than five words, which exposes a design with a fixed header size. It also builds a UDP frame whose true sum is exactly zero, so a design missing the 0xFFFF substitution sends zero, which a receiver reads as "no checksum". Further cases are a flag set with IPv4 clear, a UDP frame with no checksum requested (whose stale field must be cleared), and start pulses during both phases, which a design lacking the busy guard would turn into a truncated or restarted burst.

// File: rtl/tx_csum_offload.sv
module tx_csum_offload #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              start,
  input  logic [ADDR_W:0]   frame_len,
  output logic              busy,
  output logic              out_valid,
  output logic [7:0]        out_data,
  output logic              out_last
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LEN_W = ADDR_W + 1;
  localparam int PW    = ADDR_W + 2;
  localparam int CB    = 8;

  typedef enum logic [1:0] {IDLE, SCAN, SEND} state_t;
  state_t state;

  logic [7:0]        mem [DEPTH];
  logic [PW-1:0]     idx, l3, l4, ip_end, ck_pos;
  logic [LEN_W-1:0]  len_r;
  logic              do_ip, do_l4, udp, zero_udp;
  logic [31:0]       ip_acc, l4_acc;

  always_ff @(posedge clk)
    if (wr_en) mem[wr_addr] <= wr_data;

  // start-time decode of the control block
  logic [7:0]    cb_flags;
  logic [PW-1:0] s_l3, s_l4;
  logic [3:0]    s_ihl;
  logic          accept;
  assign cb_flags = mem[0];
  assign s_l3     = PW'(CB) + PW'(mem[3]);
  assign s_l4     = s_l3 + PW'(mem[2]);
  assign s_ihl    = mem[s_l3[ADDR_W-1:0]][3:0];
  assign accept   = (state == IDLE) && start && (frame_len > LEN_W'(CB))
                    && (frame_len <= LEN_W'(DEPTH));

  // per-byte contributions during the scan
  logic [7:0]    cur;
  logic [PW-1:0] rel3, rel4, last_idx;
  logic          in_ip, in_ps, is_proto, in_l4;
  logic [31:0]   ip_add, l4_add;
  assign cur      = mem[idx[ADDR_W-1:0]];
  assign rel3     = idx - l3;
  assign rel4     = idx - l4;
  assign last_idx = PW'(len_r) - PW'(1);
  assign in_ip    = (idx >= l3) && (idx < ip_end) && (rel3 != PW'(10)) && (rel3 != PW'(11));
  assign in_ps    = (idx >= l3) && (rel3 >= PW'(12)) && (rel3 < PW'(20));
  assign is_proto = (idx >= l3) && (rel3 == PW'(9));
  assign in_l4    = (idx >= l4) && (idx != ck_pos) && (idx != ck_pos + PW'(1));

  function automatic logic [31:0] place(input logic [7:0] b, input logic odd);
    return odd ? {24'd0, b} : {16'd0, b, 8'd0};
  endfunction

  assign ip_add = in_ip ? place(cur, rel3[0]) : 32'd0;
  assign l4_add = (in_ps ? place(cur, rel3[0]) : 32'd0)
                + (is_proto ? {24'd0, cur} : 32'd0)
                + (in_l4 ? place(cur, rel4[0]) : 32'd0);

  // fold and finish
  function automatic logic [15:0] fold(input logic [31:0] s);
    logic [16:0] f1;
    logic [16:0] f2;
    f1 = {1'b0, s[15:0]} + {1'b0, s[31:16]};
    f2 = {1'b0, f1[15:0]} + {16'd0, f1[16]};
    return f2[15:0];
  endfunction

  logic [15:0] ip_ck, l4_raw, l4_ck, l4_len;
  assign l4_len = 16'(PW'(len_r) - l4);
  assign ip_ck  = ~fold(ip_acc);
  assign l4_raw = ~fold(l4_acc + {16'd0, l4_len});
  assign l4_ck  = (udp && l4_raw == 16'd0) ? 16'hFFFF : l4_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= IDLE;
      idx      <= '0;
      l3       <= '0;
      l4       <= '0;
      ip_end   <= '0;
      ck_pos   <= '0;
      len_r    <= '0;
      do_ip    <= 1'b0;
      do_l4    <= 1'b0;
      udp      <= 1'b0;
      zero_udp <= 1'b0;
      ip_acc   <= '0;
      l4_acc   <= '0;
    end else begin
      case (state)
        IDLE: if (accept) begin
          state    <= SCAN;
          idx      <= PW'(CB);
          len_r    <= frame_len;
          l3       <= s_l3;
          l4       <= s_l4;
          ip_end   <= s_l3 + PW'({s_ihl, 2'b00});
          ck_pos   <= s_l4 + (cb_flags[5] ? PW'(6) : PW'(16));
          udp      <= cb_flags[5];
          do_ip    <= cb_flags[7] & cb_flags[4];
          do_l4    <= cb_flags[7] & cb_flags[6] & cb_flags[3];
          zero_udp <= cb_flags[7] & cb_flags[6] & cb_flags[5] & ~cb_flags[3];
          ip_acc   <= '0;
          l4_acc   <= '0;
        end
        SCAN: begin
          ip_acc <= ip_acc + ip_add;
          l4_acc <= l4_acc + l4_add;
          if (idx == last_idx) begin
            idx   <= PW'(CB);
            state <= SEND;
          end else begin
            idx <= idx + PW'(1);
          end
        end
        SEND: begin
          if (idx == last_idx) state <= IDLE;
          else idx <= idx + PW'(1);
        end
        default: state <= IDLE;
      endcase
    end
  end

  // output with field substitution
  logic hit_ip_hi, hit_ip_lo, hit_l4_hi, hit_l4_lo;
  assign hit_ip_hi = do_ip && (idx == l3 + PW'(10));
  assign hit_ip_lo = do_ip && (idx == l3 + PW'(11));
  assign hit_l4_hi = (do_l4 || zero_udp) && (idx == ck_pos);
  assign hit_l4_lo = (do_l4 || zero_udp) && (idx == ck_pos + PW'(1));

  always_comb begin
    out_data = cur;
    if (hit_ip_hi)      out_data = ip_ck[15:8];
    else if (hit_ip_lo) out_data = ip_ck[7:0];
    else if (hit_l4_hi) out_data = zero_udp ? 8'd0 : l4_ck[15:8];
    else if (hit_l4_lo) out_data = zero_udp ? 8'd0 : l4_ck[7:0];
  end

  assign busy      = (state != IDLE);
  assign out_valid = (state == SEND);
  assign out_last  = (state == SEND) && (idx == last_idx);
endmodule

module tx_csum_offload_chk #(
  parameter int ADDR_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [ADDR_W:0] frame_len,
  input logic            busy,
  input logic            out_valid,
  input logic            out_last
);
  // R9
  burst_unbroken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |=> out_valid);
  // R9
  end_of_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |=> !out_valid && !busy);
  // R9
  start_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && frame_len > 9'(8) && frame_len <= 9'(1 << ADDR_W) |=> busy);
  // R10
  short_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && frame_len <= 9'(8) |=> !busy);
  // R9
  scan_before_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid && !out_last);
endmodule

bind tx_csum_offload tx_csum_offload_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .frame_len(frame_len),
  .busy(busy), .out_valid(out_valid), .out_last(out_last)
);

// File: tb/tb_tx_csum_offload.sv
module tb_tx_csum_offload;
  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, start = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic [8:0] frame_len = '0;
  logic       busy, out_valid, out_last;
  logic [7:0] out_data;

  tx_csum_offload dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .frame_len(frame_len), .busy(busy),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last));

  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  logic [7:0] fr [0:255];
  logic [7:0] ex [0:255];
  logic [7:0] got[0:255];
  int got_n, first_cnt, after_busy, after_valid;

  // flags, off3, off2, len, ihl, seed
  localparam logic [47:0] VEC [0:7] = '{
    {8'hD8, 8'd14, 8'd20, 8'd82,  8'd5, 8'd1},
    {8'hE8, 8'd0,  8'd24, 8'd53,  8'd6, 8'd2},
    {8'hF0, 8'd14, 8'd20, 8'd60,  8'd5, 8'd3},
    {8'h90, 8'd2,  8'd20, 8'd50,  8'd5, 8'd4},
    {8'h58, 8'd14, 8'd20, 8'd82,  8'd5, 8'd5},
    {8'h98, 8'd6,  8'd20, 8'd70,  8'd5, 8'd6},
    {8'hD8, 8'd6,  8'd20, 8'd61,  8'd5, 8'd7},
    {8'hF8, 8'd0,  8'd28, 8'd120, 8'd7, 8'd8}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] oadd(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction

  function automatic logic [15:0] ref_ip(input int l3, input int ihl);
    logic [15:0] s = 16'd0;
    for (int k = 0; k < ihl * 2; k++)
      if (k != 5) s = oadd(s, {fr[l3 + 2*k], fr[l3 + 2*k + 1]});
    return ~s;
  endfunction

  function automatic logic [15:0] ref_l4raw(input int l3, input int l4, input int len,
                                            input bit u);
    logic [15:0] s = 16'd0;
    int nb = len - l4;
    int ckw = u ? 3 : 8;
    for (int k = 6; k < 10; k++) s = oadd(s, {fr[l3 + 2*k], fr[l3 + 2*k + 1]});
    s = oadd(s, {8'd0, fr[l3 + 9]});
    s = oadd(s, 16'(nb));
    for (int k = 0; 2*k < nb; k++)
      if (k != ckw)
        s = oadd(s, {fr[l4 + 2*k], (2*k + 1 < nb) ? fr[l4 + 2*k + 1] : 8'd0});
    return ~s;
  endfunction

  task automatic fill(input logic [47:0] v);
    int l3 = 8 + int'(v[39:32]);
    for (int i = 0; i < 256; i++) fr[i] = 8'(i * 29 + int'(v[7:0]) * 7 + 3);
    fr[0] = v[47:40]; fr[1] = 8'd0; fr[2] = v[31:24]; fr[3] = v[39:32];
    fr[l3] = 8'h40 | v[15:8];
  endtask

  task automatic build_exp(input logic [47:0] v);
    logic [7:0] f = v[47:40];
    int l3 = 8 + int'(v[39:32]);
    int l4 = l3 + int'(v[31:24]);
    int len = int'(v[23:16]);
    int cp;
    logic [15:0] c;
    for (int j = 0; j < len - 8; j++) ex[j] = fr[j + 8];
    if (f[7] && f[4]) begin
      c = ref_ip(l3, int'(v[15:8]));
      ex[l3 + 2] = c[15:8]; ex[l3 + 3] = c[7:0];
    end
    if (f[7] && f[6]) begin
      cp = l4 + (f[5] ? 6 : 16) - 8;
      if (f[3]) begin
        c = ref_l4raw(l3, l4, len, f[5]);
        if (f[5] && c == 16'd0) c = 16'hFFFF;
        ex[cp] = c[15:8]; ex[cp + 1] = c[7:0];
      end else if (f[5]) begin
        ex[cp] = 8'd0; ex[cp + 1] = 8'd0;
      end
    end
  endtask

  task automatic load(input int len);
    for (int i = 0; i < len; i++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 8'(i); wr_data = fr[i];
    end
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic run(input int len, input bit inject);
    int cnt;
    @(negedge clk); start = 1'b1; frame_len = 9'(len);
    @(negedge clk); start = 1'b0;
    cnt = 1; got_n = 0; first_cnt = -1;
    forever begin
      if (out_valid) begin
        if (first_cnt < 0) first_cnt = cnt;
        got[got_n] = out_data; got_n++;
      end
      if (out_last || cnt > 1000) break;
      if (inject && (cnt == 3 || cnt == len - 8 + 3)) begin
        start = 1'b1; frame_len = 9'd20;
      end else start = 1'b0;
      @(negedge clk); cnt++;
    end
    start = 1'b0;
    @(negedge clk);
    after_busy = busy; after_valid = out_valid;
  endtask

  task automatic compare(input int len, input string req);
    int bad = -1;
    chk(got_n == len - 8, req, "byte count", got_n, len - 8);
    for (int j = 0; j < len - 8 && j < got_n; j++)
      if (bad < 0 && got[j] !== ex[j]) bad = j;
    if (bad < 0) chk(1'b1, req, "bytes", 0, 0);
    else chk(1'b0, req, $sformatf("byte %0d", bad), got[bad], ex[bad]);
  endtask

  function automatic string req_of(input int vi, input logic [7:0] f);
    if (vi == 6) return "R7";
    if (vi == 7) return "R3";
    if (!f[7]) return "R8";
    if (f[6] && f[5] && !f[3]) return "R6";
    if (f[6] && f[3]) return f[5] ? "R5" : "R4";
    return "R3";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy == 1'b0 && out_valid == 1'b0 && out_last == 1'b0, "R11", "outputs in reset",
        {busy, out_valid, out_last}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, out_valid, out_last} == 3'b000, "R11", "outputs after reset",
        {busy, out_valid, out_last}, 0);

    // R1 control-block decode drives every vector below
    for (int vi = 0; vi < 8; vi++) begin
      fill(VEC[vi]);
      build_exp(VEC[vi]);
      load(int'(VEC[vi][23:16]));
      run(int'(VEC[vi][23:16]), 1'b0);
      compare(int'(VEC[vi][23:16]), req_of(vi, VEC[vi][47:40]));
      chk(first_cnt == int'(VEC[vi][23:16]) - 7, "R9", "first byte cycle",
          first_cnt, int'(VEC[vi][23:16]) - 7);
      chk(after_busy == 0, "R9", "busy after last", after_busy, 0);
    end

    // R5 UDP sum exactly zero is sent as FFFF
    fill({8'hE8, 8'd0, 8'd20, 8'd48, 8'd5, 8'd9});
    fr[46] = 8'd0; fr[47] = 8'd0;
    begin
      logic [15:0] c;
      c = ref_l4raw(8, 28, 48, 1'b1);
      fr[46] = c[15:8]; fr[47] = c[7:0];
    end
    build_exp({8'hE8, 8'd0, 8'd20, 8'd48, 8'd5, 8'd9});
    load(48);
    run(48, 1'b0);
    compare(48, "R5");
    chk(got_n > 27 && got[26] == 8'hFF && got[27] == 8'hFF, "R5", "zero-sum UDP field",
        {got[26], got[27]}, 16'hFFFF);

    // R10 start pulses during scan and send are ignored
    fill(VEC[0]);
    build_exp(VEC[0]);
    load(82);
    run(82, 1'b1);
    compare(82, "R10");
    chk(after_busy == 0 && after_valid == 0, "R10", "no restart after burst",
        {after_busy, after_valid}, 0);

    // R10 too-short length is ignored
    @(negedge clk); start = 1'b1; frame_len = 9'd8;
    @(negedge clk); start = 1'b0;
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        if (busy || out_valid) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R10", "short start activity", seen, 0);
    end

    // R2 minimal frame: one byte after the control block
    fill({8'h00, 8'd0, 8'd0, 8'd9, 8'd5, 8'd10});
    fr[8] = 8'hA5;
    load(9);
    run(9, 1'b0);
    chk(got_n == 1 && got[0] == 8'hA5, "R2", "single byte frame", got[0], 8'hA5);
    chk(first_cnt == 2, "R9", "single byte timing", first_cnt, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule